// File: doc/BRIEF.md
# Pin I/O Controller with Event Detection

A 32-pin general-purpose I/O block with a 32-bit memory-mapped register port. Software picks the direction of each pin, drives output values (written whole, or changed bit by bit through set and clear strobes that are safe against read-modify-write races), and reads the pin levels after a two-stage synchronizer.

Each pin can watch for any mix of four conditions: low level, high level, rising edge and falling edge. A condition that occurs sets a sticky status bit, which is cleared by writing a one to it. Pins whose interrupt enable is set drive a single registered interrupt line. The enable mask is changed only through its own set and clear strobes.

The register offsets are fixed by the software that uses the block. Reads are combinational: `rdata_o` returns the addressed register in the same cycle as the request.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset the direction register reads all ones, so every pin is an input. The output data, enable, status and all four trigger registers read zero, and `irq_o` is low.
- R2: The direction register sits at offset 0x134. A 1 in a bit makes that pin an input and a 0 makes it an output. It drives `pin_in_mode_o` and reads back at the same offset.
- R3: The output data register sits at offset 0x13C. A write replaces it, `pin_o` follows from the next cycle, and a read returns the value being driven.
- R4: Writing a mask to offset 0x194 sets the masked output bits, and writing a mask to offset 0x190 clears them. Bits written as 0 keep their value, and both offsets read as zero.
- R5: The input data register sits at offset 0x138 and is read-only. It shows `pin_i` two clock edges after a change, and a write to it has no effect.
- R6: A pin with rising-detect (offset 0x148) or falling-detect (offset 0x14C) set raises its status bit at the edge after the synchronized value changes in that direction.
- R7: A pin with low-detect (offset 0x140) or high-detect (offset 0x144) set sets its status bit on every cycle the synchronized level matches, even in the cycle a clear is written. Setting both makes the bit permanently set.
- R8: The status register sits at offset 0x02C. Writing 1 clears a bit, and bits written as 0 are untouched. Status bits are sticky.
- R9: Writing ones to offset 0x034 sets enable bits, and writing ones to offset 0x038 clears them. Both offsets read back the enable mask.
- R10: `irq_o` is high exactly one cycle after any pin has both its status bit and its enable bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 12 | Byte offset of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the request cycle |
| pin_i | input | 32 | Asynchronous pin levels |
| pin_o | output | 32 | Output data to the pads |
| pin_in_mode_o | output | 32 | 1 = pin is an input, 0 = pin drives |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach is a level condition that is still present in the very cycle software writes the clear. The clear and the new event meet at the same edge, and the event must win. The stimulus holds a pin low with low-detect armed, writes a one to its status bit, and reads status in the following cycle. It also arms low-detect and high-detect together on a single pin and confirms the request never drops, even while clears are written. The bench model tracks the synchronizer and the previous-sample stage cycle by cycle. Because of this, edge events and interrupt timing are compared at the exact edge where they should appear.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  localparam int unsigned OFF_STATUS  = 'h02C;
  localparam int unsigned OFF_EN_SET  = 'h034;
  localparam int unsigned OFF_EN_CLR  = 'h038;
  localparam int unsigned OFF_DIR     = 'h134;
  localparam int unsigned OFF_DIN     = 'h138;
  localparam int unsigned OFF_DOUT    = 'h13C;
  localparam int unsigned OFF_LOW     = 'h140;
  localparam int unsigned OFF_HIGH    = 'h144;
  localparam int unsigned OFF_RISE    = 'h148;
  localparam int unsigned OFF_FALL    = 'h14C;
  localparam int unsigned OFF_DOUT_CLR = 'h190;
  localparam int unsigned OFF_DOUT_SET = 'h194;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stage_q[g] <= '0;
        else         stage_q[g] <= stage_q[g-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_event.sv
module gpio_event #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] low_en_i,
  input  logic [W-1:0] high_en_i,
  input  logic [W-1:0] rise_en_i,
  input  logic [W-1:0] fall_en_i,
  output logic [W-1:0] ev_o
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= lvl_i;

  always_comb begin
    ev_o = (~lvl_i & low_en_i)
         | ( lvl_i & high_en_i)
         | ( lvl_i & ~prev_q & rise_en_i)
         | (~lvl_i &  prev_q & fall_en_i);
  end
endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned ADDR_W      = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NPINS-1:0]  wdata_i,
  output logic [NPINS-1:0]  rdata_o,
  input  logic [NPINS-1:0]  pin_i,
  output logic [NPINS-1:0]  pin_o,
  output logic [NPINS-1:0]  pin_in_mode_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STATUS   = ADDR_W'(OFF_STATUS);
  localparam logic [ADDR_W-1:0] A_EN_SET   = ADDR_W'(OFF_EN_SET);
  localparam logic [ADDR_W-1:0] A_EN_CLR   = ADDR_W'(OFF_EN_CLR);
  localparam logic [ADDR_W-1:0] A_DIR      = ADDR_W'(OFF_DIR);
  localparam logic [ADDR_W-1:0] A_DIN      = ADDR_W'(OFF_DIN);
  localparam logic [ADDR_W-1:0] A_DOUT     = ADDR_W'(OFF_DOUT);
  localparam logic [ADDR_W-1:0] A_LOW      = ADDR_W'(OFF_LOW);
  localparam logic [ADDR_W-1:0] A_HIGH     = ADDR_W'(OFF_HIGH);
  localparam logic [ADDR_W-1:0] A_RISE     = ADDR_W'(OFF_RISE);
  localparam logic [ADDR_W-1:0] A_FALL     = ADDR_W'(OFF_FALL);
  localparam logic [ADDR_W-1:0] A_DOUT_CLR = ADDR_W'(OFF_DOUT_CLR);
  localparam logic [ADDR_W-1:0] A_DOUT_SET = ADDR_W'(OFF_DOUT_SET);

  logic [NPINS-1:0] dout_q, dir_q, enable_q, status_q;
  logic [NPINS-1:0] low_q, high_q, rise_q, fall_q;
  logic [NPINS-1:0] din, ev, clr_mask;
  logic             irq_q, wr, rd;

  assign wr = req_i & we_i;
  assign rd = req_i & ~we_i;

  gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (din)
  );

  gpio_event #(.W(NPINS)) u_event (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lvl_i    (din),
    .low_en_i (low_q),
    .high_en_i(high_q),
    .rise_en_i(rise_q),
    .fall_en_i(fall_q),
    .ev_o     (ev)
  );

  assign clr_mask = (wr && addr_i == A_STATUS) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dout_q   <= '0;
      dir_q    <= '1;
      enable_q <= '0;
      low_q    <= '0;
      high_q   <= '0;
      rise_q   <= '0;
      fall_q   <= '0;
    end else if (wr) begin
      unique case (addr_i)
        A_DOUT:     dout_q   <= wdata_i;
        A_DOUT_SET: dout_q   <= dout_q | wdata_i;
        A_DOUT_CLR: dout_q   <= dout_q & ~wdata_i;
        A_DIR:      dir_q    <= wdata_i;
        A_EN_SET:   enable_q <= enable_q | wdata_i;
        A_EN_CLR:   enable_q <= enable_q & ~wdata_i;
        A_LOW:      low_q    <= wdata_i;
        A_HIGH:     high_q   <= wdata_i;
        A_RISE:     rise_q   <= wdata_i;
        A_FALL:     fall_q   <= wdata_i;
        default: ;
      endcase
    end
  end

  // a fresh event beats a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) status_q <= '0;
    else         status_q <= (status_q & ~clr_mask) | ev;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_q & enable_q);

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      unique case (addr_i)
        A_STATUS:           rdata_o = status_q;
        A_EN_SET, A_EN_CLR: rdata_o = enable_q;
        A_DIR:              rdata_o = dir_q;
        A_DIN:              rdata_o = din;
        A_DOUT:             rdata_o = dout_q;
        A_LOW:              rdata_o = low_q;
        A_HIGH:             rdata_o = high_q;
        A_RISE:             rdata_o = rise_q;
        A_FALL:             rdata_o = fall_q;
        default:            rdata_o = '0;
      endcase
    end
  end

  assign pin_o         = dout_q;
  assign pin_in_mode_o = dir_q;
  assign irq_o         = irq_q;
endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NPINS-1:0]  wdata_i,
  input logic [NPINS-1:0]  pin_o,
  input logic [NPINS-1:0]  pin_in_mode_o,
  input logic [NPINS-1:0]  status_q,
  input logic [NPINS-1:0]  enable_q,
  input logic              irq_o
);
  logic             wr;
  logic [NPINS-1:0] clr_m;

  assign wr    = req_i & we_i;
  assign clr_m = (wr && addr_i == ADDR_W'(OFF_STATUS)) ? wdata_i : '0;

  AST_DIR_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(OFF_DIR)) |=> pin_in_mode_o == $past(wdata_i)); // R2

  AST_DOUT_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(OFF_DOUT_SET)) |=>
      ((pin_o & $past(wdata_i)) == $past(wdata_i)) && ((pin_o & ~$past(wdata_i)) == ($past(pin_o) & ~$past(wdata_i)))); // R4

  AST_DOUT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(OFF_DOUT_CLR)) |=>
      ((pin_o & $past(wdata_i)) == '0) && ((pin_o & ~$past(wdata_i)) == ($past(pin_o) & ~$past(wdata_i)))); // R4

  AST_STATUS_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(status_q) & ~$past(clr_m) & ~status_q) == '0); // R8

  AST_EN_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(OFF_EN_SET)) |=> (enable_q & $past(wdata_i)) == $past(wdata_i)); // R9

  AST_EN_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr && addr_i == ADDR_W'(OFF_EN_CLR)) |=> (enable_q & $past(wdata_i)) == '0); // R9

  AST_IRQ_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(status_q & enable_q)) |=> irq_o); // R10

  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(status_q & enable_q)) |=> !irq_o); // R10
endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .addr_i       (addr_i),
  .wdata_i      (wdata_i),
  .pin_o        (pin_o),
  .pin_in_mode_o(pin_in_mode_o),
  .status_q     (status_q),
  .enable_q     (enable_q),
  .irq_o        (irq_o)
);

// File: tb/gpio_irq_ctrl_tb.sv
module gpio_irq_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0, we_i = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0, pin_i = '0;
  logic [31:0] rdata_o, pin_o, pin_in_mode_o;
  logic        irq_o;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [31:0] pins = '0;

  // reference model state
  logic [31:0] m_out, m_dir, m_en, m_st, m_lo, m_hi, m_ri, m_fa;
  logic [31:0] m_s1, m_s2, m_prev;
  logic        m_irq;

  always #2 clk = ~clk;

  gpio_irq_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .pin_i(pin_i), .pin_o(pin_o),
    .pin_in_mode_o(pin_in_mode_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] m_read(input logic [11:0] a);
    case (a)
      12'h02C:          return m_st;
      12'h034, 12'h038: return m_en;
      12'h134:          return m_dir;
      12'h138:          return m_s2;
      12'h13C:          return m_out;
      12'h140:          return m_lo;
      12'h144:          return m_hi;
      12'h148:          return m_ri;
      12'h14C:          return m_fa;
      default:          return 32'h0;
    endcase
  endfunction

  task automatic m_reset();
    m_out = '0; m_dir = '1; m_en = '0; m_st = '0; m_lo = '0; m_hi = '0;
    m_ri = '0; m_fa = '0; m_s1 = '0; m_s2 = '0; m_prev = '0; m_irq = 1'b0;
  endtask

  task automatic m_step(input logic rq, input logic we, input logic [11:0] a, input logic [31:0] wd);
    logic [31:0] ev, clr;
    ev = 32'h0;
    for (int i = 0; i < 32; i++) begin
      if (m_lo[i] && !m_s2[i]) ev[i] = 1'b1;
      if (m_hi[i] &&  m_s2[i]) ev[i] = 1'b1;
      if (m_ri[i] &&  m_s2[i] && !m_prev[i]) ev[i] = 1'b1;
      if (m_fa[i] && !m_s2[i] &&  m_prev[i]) ev[i] = 1'b1;
    end
    clr = (rq && we && a == 12'h02C) ? wd : 32'h0;
    m_irq = (m_st & m_en) != 0;
    m_st = (m_st & ~clr) | ev;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pins;
    if (rq && we) begin
      case (a)
        12'h13C: m_out = wd;
        12'h194: m_out = m_out | wd;
        12'h190: m_out = m_out & ~wd;
        12'h134: m_dir = wd;
        12'h034: m_en = m_en | wd;
        12'h038: m_en = m_en & ~wd;
        12'h140: m_lo = wd;
        12'h144: m_hi = wd;
        12'h148: m_ri = wd;
        12'h14C: m_fa = wd;
        default: ;
      endcase
    end
  endtask

  // one clock: compare registered outputs, drive, compare read data, advance model
  task automatic cyc(input logic rq, input logic we, input logic [11:0] a,
                     input logic [31:0] wd, input string tag);
    @(negedge clk);
    check("R10 irq_o", {31'h0, irq_o}, {31'h0, m_irq});
    check("R3 pin_o", pin_o, m_out);
    check("R2 pin_in_mode_o", pin_in_mode_o, m_dir);
    req_i = rq; we_i = we; addr_i = a; wdata_i = wd; pin_i = pins;
    #1;
    if (rq && !we) check(tag, rdata_o, m_read(a));
    @(posedge clk);
    m_step(rq, we, a, wd);
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input string tag);
    cyc(1'b1, 1'b1, a, d, tag);
  endtask
  task automatic rd(input logic [11:0] a, input string tag);
    cyc(1'b1, 1'b0, a, 32'h0, tag);
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 12'h0, 32'h0, "idle");
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    @(negedge clk) rst_ni = 1'b1;

    // R1 reset values
    rd(12'h134, "R1 dir reset");
    rd(12'h13C, "R1 dout reset");
    rd(12'h034, "R1 enable reset");
    rd(12'h02C, "R1 status reset");
    rd(12'h140, "R1 low reset");
    rd(12'h144, "R1 high reset");
    rd(12'h148, "R1 rise reset");
    rd(12'h14C, "R1 fall reset");

    // R2 direction
    wr(12'h134, 32'hFFFF_0000, "R2");
    rd(12'h134, "R2 dir readback");

    // R3 output data direct
    wr(12'h13C, 32'h1234_5678, "R3");
    rd(12'h13C, "R3 dout readback");

    // R4 set/clear strobes
    wr(12'h194, 32'h8000_000F, "R4");
    rd(12'h13C, "R4 after set");
    wr(12'h190, 32'h0000_0070, "R4");
    rd(12'h13C, "R4 after clear");
    rd(12'h194, "R4 set reads zero");
    rd(12'h190, "R4 clear reads zero");

    // R5 input synchronization, read-only
    pins = 32'hA5A5_A5A5;
    rd(12'h138, "R5 din before sync");
    rd(12'h138, "R5 din after one edge");
    rd(12'h138, "R5 din after two edges");
    wr(12'h138, 32'h0, "R5");
    rd(12'h138, "R5 din write ignored");
    pins = 32'h0;
    idle(4);

    // R6 edge detection with R9 enables and R10 interrupt
    wr(12'h148, 32'h0000_0001, "R6");
    wr(12'h14C, 32'h0000_0002, "R6");
    wr(12'h034, 32'h0000_0003, "R9");
    rd(12'h034, "R9 enable set readback");
    rd(12'h038, "R9 enable clear-offset readback");
    pins = 32'h0000_0003;
    idle(4);
    rd(12'h02C, "R6 rising sets bit0 only");
    pins = 32'h0000_0001;
    idle(4);
    rd(12'h02C, "R6 falling sets bit1");
    // R8 partial clear
    wr(12'h02C, 32'h0000_0001, "R8");
    rd(12'h02C, "R8 only bit0 cleared");
    wr(12'h02C, 32'h0000_0000, "R8");
    rd(12'h02C, "R8 zero write no effect");
    wr(12'h02C, 32'h0000_0002, "R8");
    rd(12'h02C, "R8 all clear");
    idle(2);

    // R7 level detection persists through clear
    wr(12'h140, 32'h0000_0010, "R7");
    idle(3);
    rd(12'h02C, "R7 low level set");
    wr(12'h02C, 32'h0000_0010, "R7");
    rd(12'h02C, "R7 reset by level after clear");
    wr(12'h140, 32'h0000_0000, "R7");
    wr(12'h02C, 32'h0000_0010, "R7");
    rd(12'h02C, "R7 cleared once level disarmed");
    // both level types: continuous
    wr(12'h140, 32'h0000_0020, "R7");
    wr(12'h144, 32'h0000_0020, "R7");
    wr(12'h034, 32'h0000_0020, "R9");
    idle(2);
    pins = 32'h0000_0021;
    for (int i = 0; i < 4; i++) begin
      wr(12'h02C, 32'h0000_0020, "R7");
      rd(12'h02C, "R7 both levels continuous");
    end
    // R9 enable clear drops R10 interrupt
    wr(12'h038, 32'h0000_0023, "R9");
    rd(12'h034, "R9 enable cleared");
    idle(3);
    wr(12'h140, 32'h0, "R7");
    wr(12'h144, 32'h0, "R7");
    wr(12'h02C, 32'hFFFF_FFFF, "R8");
    rd(12'h02C, "R8 full clear");
    idle(3);
    finish_run();
  end
endmodule